// File: doc/BRIEF.md
# Direct-Mapped Write-Back Cache Without Write Allocation

This block sits between a processor-side word port and a one-word-per-transaction physical memory port. It keeps four lines of two 32-bit words each. A byte address picks exactly one line, so placement is direct mapped. Reads that hit are answered from the line. Reads that miss bring the whole two-word block into the line. If the line being replaced is both valid and modified, its two words go back to memory before the new block is fetched.

Writes that hit change only the cached word and mark the line modified. Writes that miss go straight to memory and leave every line as it was. The processor holds `cpu_req` and its request fields steady until `cpu_ready` pulses. Memory requests are held, with a stable address, until the memory returns `mem_ack`. Both sides carry one word at a time.

Top module: `dm_wbna_cache`

## Requirements
- R1: Reset clears every line's valid and modified flags. `cpu_ready` and `mem_req` are low during reset, and the first read after reset misses and fetches its block from memory.
- R2: The 6-bit byte address is split as follows: bits [1:0] select a byte and are ignored, bit [2] selects the word in the block, bits [4:3] select the line, and bit [5] is the tag. Every memory address issued has bits [1:0] equal to zero.
- R3: A read whose line is valid with a matching tag returns the cached word. `cpu_ready` rises in the cycle after the request is taken, and no memory transaction takes place.
- R4: A read miss on an invalid or unmodified line performs two memory reads: word 0 first, then word 1 of the new block. The line then becomes valid and unmodified, and the requested word is returned.
- R5: A read miss on a valid, modified line first writes the old word 0 and then the old word 1 to their old-tag addresses. After that it performs the two fills of R4. No write occurs once the fill has begun.
- R6: A write hit updates the cached word and marks the line modified without any memory transaction. Memory sees the value only when the line is later evicted.
- R7: A write miss performs exactly one memory write of the request word to its address. No line changes, so a later read of that block misses.
- R8: `cpu_ready` is a single-cycle pulse, and read data is valid in that cycle. `mem_req`, `mem_we` and `mem_addr` stay unchanged until `mem_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| cpu_req | input | 1 | Processor request, held until `cpu_ready` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 6 | Byte address |
| cpu_wdata | input | 32 | Write word |
| cpu_rdata | output | 32 | Read word, valid while `cpu_ready` is high |
| cpu_ready | output | 1 | One-cycle completion pulse |
| mem_req | output | 1 | Memory transaction request, held until `mem_ack` |
| mem_we | output | 1 | 1 = memory write, 0 = memory read |
| mem_addr | output | 6 | Word-aligned byte address to memory |
| mem_wdata | output | 32 | Word written to memory |
| mem_rdata | input | 32 | Word read from memory, valid with `mem_ack` |
| mem_ack | input | 1 | One-cycle completion of a memory transaction |

## Verification
The bench sweeps every word with reads, then with writes, then with reads again. It follows this with a long mixed sequence, so that lines alias on every index with both tags and with both clean and modified victims. The sequence ends with a reset that must drop modified data without writing it back. For each access the bench checks the memory transactions it expects, in order, with their addresses and data. A design that skips or reorders the victim write-back shows up as a missing or misplaced write. One that allocates on a write miss turns a later miss into a hit. One that forgets to set the modified flag leaves memory stale at the final comparison. One that decodes the wrong address bits returns the wrong word when the byte offset is nonzero.

// File: rtl/dmc_pkg.sv
package dmc_pkg;

  // Controller states; eviction and fill each walk the block one word per beat.
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CHECK,
    ST_EVICT,
    ST_FILL,
    ST_WMISS,
    ST_DONE
  } dmc_state_t;

endpackage

// File: rtl/dmc_tag_store.sv
module dmc_tag_store #(
  parameter int SETS  = 4,
  parameter int IDX_W = 2,
  parameter int TAG_W = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] idx,
  input  logic             fill_en,
  input  logic [TAG_W-1:0] fill_tag,
  input  logic             mark_dirty,
  output logic             line_valid,
  output logic             line_dirty,
  output logic [TAG_W-1:0] line_tag
);

  logic [SETS-1:0]  valid_q, valid_d;
  logic [SETS-1:0]  dirty_q, dirty_d;
  logic [TAG_W-1:0] tag_q [SETS];

  // Per-line next-state: a fill makes the line valid and clean,
  // a write hit marks it modified.
  for (genvar s = 0; s < SETS; s++) begin : g_line
    localparam logic [IDX_W-1:0] LINE_ID = IDX_W'(s);
    logic this_line;
    assign this_line  = (idx == LINE_ID);
    assign valid_d[s] = (fill_en && this_line) ? 1'b1 : valid_q[s];
    assign dirty_d[s] = (fill_en && this_line)    ? 1'b0 :
                        (mark_dirty && this_line) ? 1'b1 : dirty_q[s];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      dirty_q <= '0;
    end else begin
      valid_q <= valid_d;
      dirty_q <= dirty_d;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_en) begin
      tag_q[idx] <= fill_tag;
    end
  end

  assign line_valid = valid_q[idx];
  assign line_dirty = dirty_q[idx];
  assign line_tag   = tag_q[idx];

endmodule

// File: rtl/dmc_data_store.sv
module dmc_data_store #(
  parameter int SETS   = 4,
  parameter int WPL    = 2,
  parameter int WORD_W = 32,
  parameter int IDX_W  = 2,
  parameter int SEL_W  = 1
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  idx,
  input  logic [SEL_W-1:0]  wr_sel,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [SEL_W-1:0]  rd_sel,
  output logic [WORD_W-1:0] rd_data
);

  logic [WORD_W-1:0] word_q [SETS][WPL];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      word_q[idx][wr_sel] <= wr_data;
    end
  end

  assign rd_data = word_q[idx][rd_sel];

endmodule

// File: rtl/dmc_ctrl.sv
module dmc_ctrl
  import dmc_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int WORD_W = 32,
  parameter int WPL    = 2,
  parameter int OFS_W  = 2,
  parameter int SEL_W  = 1,
  parameter int IDX_W  = 2,
  parameter int TAG_W  = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  // processor side
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [WORD_W-1:0] cpu_wdata,
  output logic              cpu_ready,
  // memory side
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic [WORD_W-1:0] mem_rdata,
  input  logic              mem_ack,
  // line state
  output logic [IDX_W-1:0]  idx,
  input  logic              line_valid,
  input  logic              line_dirty,
  input  logic [TAG_W-1:0]  line_tag,
  output logic              fill_en,
  output logic [TAG_W-1:0]  fill_tag,
  output logic              mark_dirty,
  // line data
  output logic              dw_en,
  output logic [SEL_W-1:0]  dw_sel,
  output logic [WORD_W-1:0] dw_data,
  output logic [SEL_W-1:0]  dr_sel,
  input  logic [WORD_W-1:0] dr_data
);

  localparam logic [SEL_W-1:0] LAST_BEAT = SEL_W'(WPL - 1);
  localparam logic [OFS_W-1:0] NO_OFS    = '0;

  dmc_state_t        state_q, state_d;
  logic [SEL_W-1:0]  beat_q, beat_d;
  logic              beat_en;
  logic              ld_req;
  logic              rq_we_q;
  logic [ADDR_W-1:0] rq_addr_q;
  logic [WORD_W-1:0] rq_wdata_q;

  logic [TAG_W-1:0]  rq_tag;
  logic [SEL_W-1:0]  rq_sel;
  logic              tag_hit;

  assign rq_tag  = rq_addr_q[ADDR_W-1 -: TAG_W];
  assign idx     = rq_addr_q[OFS_W+SEL_W +: IDX_W];
  assign rq_sel  = rq_addr_q[OFS_W +: SEL_W];
  assign tag_hit = line_valid && (line_tag == rq_tag);

  // Next-state and output decode.
  always_comb begin
    state_d    = state_q;
    beat_d     = beat_q;
    beat_en    = 1'b0;
    ld_req     = 1'b0;
    cpu_ready  = 1'b0;
    mem_req    = 1'b0;
    mem_we     = 1'b0;
    mem_addr   = {rq_addr_q[ADDR_W-1:OFS_W], NO_OFS};
    mem_wdata  = rq_wdata_q;
    fill_en    = 1'b0;
    fill_tag   = rq_tag;
    mark_dirty = 1'b0;
    dw_en      = 1'b0;
    dw_sel     = rq_sel;
    dw_data    = rq_wdata_q;
    dr_sel     = rq_sel;

    unique case (state_q)
      ST_IDLE: begin
        if (cpu_req) begin
          ld_req  = 1'b1;
          state_d = ST_CHECK;
        end
      end

      ST_CHECK: begin
        beat_d  = '0;
        beat_en = 1'b1;
        if (tag_hit) begin
          cpu_ready = 1'b1;
          state_d   = ST_IDLE;
          if (rq_we_q) begin
            dw_en      = 1'b1;
            mark_dirty = 1'b1;
          end
        end else if (rq_we_q) begin
          state_d = ST_WMISS;
        end else if (line_valid && line_dirty) begin
          state_d = ST_EVICT;
        end else begin
          state_d = ST_FILL;
        end
      end

      ST_EVICT: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = {line_tag, idx, beat_q, NO_OFS};
        dr_sel    = beat_q;
        mem_wdata = dr_data;
        if (mem_ack) begin
          beat_en = 1'b1;
          if (beat_q == LAST_BEAT) begin
            beat_d  = '0;
            state_d = ST_FILL;
          end else begin
            beat_d = beat_q + 1'b1;
          end
        end
      end

      ST_FILL: begin
        mem_req  = 1'b1;
        mem_addr = {rq_tag, idx, beat_q, NO_OFS};
        dw_sel   = beat_q;
        dw_data  = mem_rdata;
        if (mem_ack) begin
          dw_en   = 1'b1;
          beat_en = 1'b1;
          if (beat_q == LAST_BEAT) begin
            beat_d  = '0;
            fill_en = 1'b1;
            state_d = ST_DONE;
          end else begin
            beat_d = beat_q + 1'b1;
          end
        end
      end

      ST_WMISS: begin
        mem_req = 1'b1;
        mem_we  = 1'b1;
        if (mem_ack) begin
          state_d = ST_DONE;
        end
      end

      ST_DONE: begin
        cpu_ready = 1'b1;
        state_d   = ST_IDLE;
      end

      default: begin
        state_d = ST_IDLE;
      end
    endcase
  end

  // State register.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      beat_q  <= '0;
    end else begin
      state_q <= state_d;
      if (beat_en) begin
        beat_q <= beat_d;
      end
    end
  end

  // Request capture, enabled only when a request is taken.
  always_ff @(posedge clk) begin
    if (ld_req) begin
      rq_we_q    <= cpu_we;
      rq_addr_q  <= cpu_addr;
      rq_wdata_q <= cpu_wdata;
    end
  end

endmodule

// File: rtl/dm_wbna_cache.sv
module dm_wbna_cache #(
  parameter int ADDR_W = 6,
  parameter int WORD_W = 32,
  parameter int SETS   = 4,
  parameter int WPL    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [WORD_W-1:0] cpu_wdata,
  output logic [WORD_W-1:0] cpu_rdata,
  output logic              cpu_ready,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic [WORD_W-1:0] mem_rdata,
  input  logic              mem_ack
);

  localparam int OFS_W = $clog2(WORD_W / 8);
  localparam int SEL_W = $clog2(WPL);
  localparam int IDX_W = $clog2(SETS);
  localparam int TAG_W = ADDR_W - OFS_W - SEL_W - IDX_W;

  logic [IDX_W-1:0]  idx;
  logic              line_valid, line_dirty;
  logic [TAG_W-1:0]  line_tag;
  logic              fill_en, mark_dirty;
  logic [TAG_W-1:0]  fill_tag;
  logic              dw_en;
  logic [SEL_W-1:0]  dw_sel, dr_sel;
  logic [WORD_W-1:0] dw_data, dr_data;

  dmc_ctrl #(
    .ADDR_W(ADDR_W), .WORD_W(WORD_W), .WPL(WPL),
    .OFS_W(OFS_W), .SEL_W(SEL_W), .IDX_W(IDX_W), .TAG_W(TAG_W)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .cpu_req    (cpu_req),
    .cpu_we     (cpu_we),
    .cpu_addr   (cpu_addr),
    .cpu_wdata  (cpu_wdata),
    .cpu_ready  (cpu_ready),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .mem_rdata  (mem_rdata),
    .mem_ack    (mem_ack),
    .idx        (idx),
    .line_valid (line_valid),
    .line_dirty (line_dirty),
    .line_tag   (line_tag),
    .fill_en    (fill_en),
    .fill_tag   (fill_tag),
    .mark_dirty (mark_dirty),
    .dw_en      (dw_en),
    .dw_sel     (dw_sel),
    .dw_data    (dw_data),
    .dr_sel     (dr_sel),
    .dr_data    (dr_data)
  );

  dmc_tag_store #(
    .SETS(SETS), .IDX_W(IDX_W), .TAG_W(TAG_W)
  ) u_tags (
    .clk        (clk),
    .rst_n      (rst_n),
    .idx        (idx),
    .fill_en    (fill_en),
    .fill_tag   (fill_tag),
    .mark_dirty (mark_dirty),
    .line_valid (line_valid),
    .line_dirty (line_dirty),
    .line_tag   (line_tag)
  );

  dmc_data_store #(
    .SETS(SETS), .WPL(WPL), .WORD_W(WORD_W), .IDX_W(IDX_W), .SEL_W(SEL_W)
  ) u_data (
    .clk     (clk),
    .wr_en   (dw_en),
    .idx     (idx),
    .wr_sel  (dw_sel),
    .wr_data (dw_data),
    .rd_sel  (dr_sel),
    .rd_data (dr_data)
  );

  assign cpu_rdata = dr_data;

endmodule

// File: rtl/dmc_checker.sv
module dmc_checker #(
  parameter int ADDR_W = 6,
  parameter int OFS_W  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_ready,
  input logic              mem_req,
  input logic              mem_we,
  input logic              mem_ack,
  input logic [ADDR_W-1:0] mem_addr
);

  AST_READY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready |=> !cpu_ready); // R8

  AST_HOLD_UNTIL_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we))); // R8

  AST_READY_NO_MEM: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready |-> !mem_req); // R3

  AST_MEM_WORD_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_addr[OFS_W-1:0] == '0)); // R2

  AST_NO_WRITE_AFTER_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ack && !mem_we) |=> !(mem_req && mem_we)); // R5

endmodule

bind dm_wbna_cache dmc_checker #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cpu_ready (cpu_ready),
  .mem_req   (mem_req),
  .mem_we    (mem_we),
  .mem_ack   (mem_ack),
  .mem_addr  (mem_addr)
);

// File: tb/tb_dm_wbna_cache.sv
`timescale 1ns/1ps
module tb_dm_wbna_cache;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_req = 1'b0;
  logic        cpu_we = 1'b0;
  logic [5:0]  cpu_addr = '0;
  logic [31:0] cpu_wdata = '0;
  logic [31:0] cpu_rdata;
  logic        cpu_ready;
  logic        mem_req, mem_we;
  logic [5:0]  mem_addr;
  logic [31:0] mem_wdata;
  logic [31:0] mem_rdata;
  logic        mem_ack;

  int n_tests = 0;
  int n_fail  = 0;

  always #2 clk = ~clk;

  dm_wbna_cache dut (
    .clk(clk), .rst_n(rst_n),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_rdata(cpu_rdata), .cpu_ready(cpu_ready),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ack(mem_ack)
  );

  // ---------------- memory model: ack one cycle after each request ----------
  logic [31:0] bmem [16];
  logic        tb_boot = 1'b1;

  function automatic logic [31:0] init_word(input int i);
    return 32'hC0DE0000 + 32'(i) * 32'h01010101;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_ack   <= 1'b0;
      mem_rdata <= '0;
    end else begin
      mem_ack <= mem_req && !mem_ack;
      if (mem_req && !mem_ack) begin
        mem_rdata <= bmem[mem_addr[5:2]];
      end
    end
  end

  always @(posedge clk) begin
    if (tb_boot) begin
      for (int i = 0; i < 16; i++) bmem[i] <= init_word(i);
    end else if (mem_req && !mem_ack && mem_we) begin
      bmem[mem_addr[5:2]] <= mem_wdata;
    end
  end

  // ---------------- transaction monitor ----------------
  int          mon_rd = 0;
  int          mon_wr = 0;
  logic [3:0]  hwe = '0;
  logic [5:0]  ha [4];
  logic [31:0] hd [4];

  always @(posedge clk) begin
    if (mem_req && mem_ack) begin
      if (mem_we) mon_wr <= mon_wr + 1;
      else        mon_rd <= mon_rd + 1;
      hwe   <= {hwe[2:0], mem_we};
      ha[3] <= ha[2]; ha[2] <= ha[1]; ha[1] <= ha[0]; ha[0] <= mem_addr;
      hd[3] <= hd[2]; hd[2] <= hd[1]; hd[1] <= hd[0]; hd[0] <= mem_wdata;
    end
  end

  // ---------------- expected state from the requirements ----------------
  logic        rv  [4];
  logic        rdy [4];
  logic        rt  [4];
  logic [31:0] rdat [4][2];
  logic [31:0] rmem [16];

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic access(input logic we, input logic [5:0] a, input logic [31:0] d,
                        input string force_tag);
    logic [1:0]  ix;
    logic        tg, w, hit, wb, ot;
    logic [3:0]  wi;
    logic [31:0] o0, o1, exp_d, got;
    int          exp_rd, exp_wr, r0, w0, cyc;
    string       tag;
    ix = a[4:3]; tg = a[5]; w = a[2]; wi = a[5:2];
    hit = rv[ix] && (rt[ix] == tg);
    wb  = !we && !hit && rv[ix] && rdy[ix];
    ot = rt[ix]; o0 = rdat[ix][0]; o1 = rdat[ix][1];
    exp_d = '0;
    if (we) begin
      if (hit) begin
        rdat[ix][w] = d; rdy[ix] = 1'b1; tag = "R6"; exp_rd = 0; exp_wr = 0;
      end else begin
        rmem[wi] = d; tag = "R7"; exp_rd = 0; exp_wr = 1;
      end
    end else if (hit) begin
      tag = "R3"; exp_rd = 0; exp_wr = 0; exp_d = rdat[ix][w];
    end else begin
      if (wb) begin
        rmem[{ot, ix, 1'b0}] = o0; rmem[{ot, ix, 1'b1}] = o1;
        tag = "R5"; exp_wr = 2;
      end else begin
        tag = "R4"; exp_wr = 0;
      end
      exp_rd = 2;
      rdat[ix][0] = rmem[{tg, ix, 1'b0}];
      rdat[ix][1] = rmem[{tg, ix, 1'b1}];
      rv[ix] = 1'b1; rdy[ix] = 1'b0; rt[ix] = tg;
      exp_d = rdat[ix][w];
    end
    if (force_tag != "") tag = force_tag;

    r0 = mon_rd; w0 = mon_wr;
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
    cyc = 0;
    do begin
      @(negedge clk);
      cyc++;
    end while (!cpu_ready && cyc < 500);
    got = cpu_rdata;
    cpu_req = 1'b0;

    chk(cpu_ready, tag, "completion", 32'(cyc), 32'd0);
    chk((mon_rd - r0) == exp_rd, tag, "memory read count", 32'(mon_rd - r0), 32'(exp_rd));
    chk((mon_wr - w0) == exp_wr, tag, "memory write count", 32'(mon_wr - w0), 32'(exp_wr));
    if (!we)
      chk(got == exp_d, (a[1:0] != 2'b00) ? "R2" : tag, "read data", got, exp_d);
    if (hit)
      chk(cyc == 1, tag, "hit latency", 32'(cyc), 32'd1);
    if (!we && !hit)
      chk(hwe[1:0] == 2'b00 && ha[1] == {tg, ix, 1'b0, 2'b00} && ha[0] == {tg, ix, 1'b1, 2'b00},
          tag, "fill order/address", {20'd0, hwe[1:0], ha[1], ha[0]},
          {22'd0, tg, ix, 1'b0, 2'b00, tg, ix, 1'b1, 2'b00});
    if (wb)
      chk(hwe == 4'b1100 && ha[3] == {ot, ix, 1'b0, 2'b00} && ha[2] == {ot, ix, 1'b1, 2'b00}
          && hd[3] == o0 && hd[2] == o1, "R5", "victim write-back", hd[3] ^ hd[2], o0 ^ o1);
    if (we && !hit)
      chk(hwe[0] && ha[0] == {wi, 2'b00} && hd[0] == d, "R7", "write-through word", hd[0], d);
    @(negedge clk);
    chk(!cpu_ready, "R8", "ready pulse width", {31'd0, cpu_ready}, 32'd0);
  endtask

  task automatic mem_compare(input string tag);
    for (int i = 0; i < 16; i++)
      chk(bmem[i] == rmem[i], tag, $sformatf("memory word %0d", i), bmem[i], rmem[i]);
  endtask

  task automatic apply_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(!cpu_ready && !mem_req, "R1", "outputs in reset", {30'd0, cpu_ready, mem_req}, 32'd0);
    for (int s = 0; s < 4; s++) begin rv[s] = 1'b0; rdy[s] = 1'b0; end
    rst_n = 1'b1;
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (200000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  // ---------------- stimulus ----------------
  initial begin
    logic [31:0] x;
    for (int i = 0; i < 16; i++) rmem[i] = init_word(i);
    for (int s = 0; s < 4; s++) begin
      rv[s] = 1'b0; rdy[s] = 1'b0; rt[s] = 1'b0;
      rdat[s][0] = '0; rdat[s][1] = '0;
    end
    repeat (2) @(negedge clk);
    tb_boot = 1'b0;
    apply_reset();

    // R1: first read after reset misses
    access(1'b0, 6'd0, '0, "R1");

    // R2 R3 R4: read sweep over all words, byte offset varied
    for (int i = 0; i < 16; i++) access(1'b0, 6'((i << 2) | (i % 4)), '0, "");

    // R6 R7: write sweep (hits on tag-1 lines, misses on tag-0 blocks)
    for (int i = 0; i < 16; i++) access(1'b1, 6'((i << 2) | ((i + 1) % 4)), 32'h5A000000 + 32'(i), "");
    mem_compare("R6");

    // R5: read sweep evicts the modified lines
    for (int i = 0; i < 16; i++) access(1'b0, 6'(i << 2), '0, "");
    mem_compare("R5");

    // mixed sequence
    x = 32'h1234567;
    for (int n = 0; n < 400; n++) begin
      x = x * 32'd1103515245 + 32'd12345;
      access(x[20], x[15:10], x ^ 32'(n), "");
    end
    mem_compare("R7");

    // R1: reset drops modified data without writing it back
    for (int i = 0; i < 16; i += 2) access(1'b0, 6'(i << 2), '0, "");
    for (int i = 0; i < 16; i += 2) access(1'b1, 6'(i << 2), 32'hBEEF0000 + 32'(i), "");
    apply_reset();
    access(1'b0, 6'd0, '0, "R1");
    access(1'b0, 6'd36, '0, "R1");
    mem_compare("R1");

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule